// File: doc/BRIEF.md
# Page-Table Address Translator with Use-Bit Replacement

This block translates virtual addresses to physical addresses through a single-level page table held entirely in on-chip registers. Each of the 64 entries covers one 16 KB page of a 20-bit virtual space. A resident entry maps its page to one of 16 physical frames. A non-resident entry holds the disk sector where the page is kept. A request yields, one cycle later, either the physical address or a page-fault flag carrying that sector.

Alongside each mapping the block keeps a use bit and a modified bit. Every successful translation marks its page as used, and a write also marks it modified. A single-cycle sweep input clears every use bit, in the way an operating system periodically ages its pages. From this state the block continuously proposes a page to evict. It picks a resident page whose use bit is clear, starting its search at a pseudo-random point, and says whether that page must be written back first. A fault handler installs new mappings through a table-write port.

Top module: `vpage_xlate`

## Requirements
- R1: A request to a resident page gives, on the cycle after `req_valid`, `rsp_valid`=1, `fault`=0 and `pa` = {frame number, the low 14 address bits unchanged}; virtual page number is `req_va[19:14]`.
- R2: A request to a non-resident page gives `fault`=1, `fault_sector` = that entry's stored 16-bit sector and `pa`=0.
- R3: A translation that hits sets that page's use bit, so that page is not proposed for eviction while another resident page has a clear use bit.
- R4: `clr_use` clears the use bit of every entry in one cycle.
- R5: `victim_found` is 1 exactly when at least one page is resident. The proposed `victim_vpn` is always resident. It has a clear use bit whenever any resident page does, and is chosen among those from a pseudo-random start point.
- R6: A write request that hits sets that page's modified bit; a read does not. `victim_dirty` equals the modified bit of the proposed page.
- R7: A table write (`tw_en`) stores `tw_resident` and `tw_data` for `tw_vpn`, and clears that entry's use and modified bits. When resident, `tw_data[3:0]` is the frame number; otherwise all 16 bits are the sector. It affects translations from the next cycle on.
- R8: After reset, `rsp_valid`, `fault` and `victim_found` are 0 and every entry is non-resident with sector 0.
- R9: In one cycle, a table write to the requested page overrides the hit's use/modified marking, and the request itself is translated with the old entry. A hit in the same cycle as `clr_use` leaves that page's use bit set.
- R10: `rsp_valid` is 1 only on the cycle after a request; a fault does not set the modified or use bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Translation request |
| req_va | input | 20 | Virtual address |
| req_write | input | 1 | Request is a write |
| clr_use | input | 1 | Clear all use bits |
| tw_en | input | 1 | Table write strobe |
| tw_vpn | input | 6 | Entry to write |
| tw_resident | input | 1 | New entry is resident |
| tw_data | input | 16 | Frame number (low 4 bits) or disk sector |
| rsp_valid | output | 1 | Translation result valid |
| pa | output | 18 | Physical address |
| fault | output | 1 | Page fault |
| fault_sector | output | 16 | Sector of the faulting page |
| victim_found | output | 1 | A resident page exists |
| victim_vpn | output | 6 | Proposed eviction page |
| victim_dirty | output | 1 | Proposed page needs write-back |

## Verification
A corrupted frame number or residency bit shows at `pa`/`fault` on the very next request to that page. A lost or stuck use bit only shows through the eviction proposal, one cycle after the state changes. It is exposed by tests that leave exactly one page with a clear use bit, so that only one proposal is legal. A wrong modified bit appears as `victim_dirty` once that page becomes the only eligible victim.

// File: rtl/vpx_pkg.sv
package vpx_pkg;
  localparam int unsigned VPX_VA_W      = 20;
  localparam int unsigned VPX_PAGE_BITS = 14;
  localparam int unsigned VPX_PPN_W     = 4;
  localparam int unsigned VPX_SEC_W     = 16;
  // feedback taps for the 6-bit start-point generator (x^6 + x^5 + 1)
  localparam logic [5:0]  VPX_LFSR_TAPS = 6'b110000;
endpackage

// File: rtl/vpx_lfsr.sv
module vpx_lfsr #(
  parameter int unsigned W = 6,
  parameter logic [W-1:0] TAPS = 6'b110000
) (
  input  logic         clk,
  input  logic         rst_n,
  output logic [W-1:0] q
);
  logic [W-1:0] q_n;

  always_comb begin
    q_n = {q[W-2:0], ^(q & TAPS)};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= {{(W-1){1'b0}}, 1'b1};
    else        q <= q_n;
  end
endmodule

// File: rtl/vpx_table.sv
module vpx_table #(
  parameter int unsigned VPN_W  = 6,
  parameter int unsigned DATA_W = 16,
  localparam int unsigned N_ENT = 1 << VPN_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_en,
  input  logic [VPN_W-1:0]  acc_vpn,
  input  logic              acc_wr,
  input  logic              clr_use,
  input  logic              tw_en,
  input  logic [VPN_W-1:0]  tw_vpn,
  input  logic              tw_resident,
  input  logic [DATA_W-1:0] tw_data,
  output logic              rd_resident,
  output logic [DATA_W-1:0] rd_data,
  output logic [N_ENT-1:0]  res_vec,
  output logic [N_ENT-1:0]  use_vec,
  output logic [N_ENT-1:0]  mod_vec
);
  logic [DATA_W-1:0] data_q [N_ENT];
  logic              acc_hit;

  assign rd_resident = res_vec[acc_vpn];
  assign rd_data     = data_q[acc_vpn];
  assign acc_hit     = acc_en && rd_resident;

  for (genvar i = 0; i < N_ENT; i++) begin : g_ent
    logic              wr_sel, hit_sel;
    logic              res_n, use_n, mod_n;
    logic [DATA_W-1:0] data_n;

    always_comb begin
      wr_sel  = tw_en && (tw_vpn == VPN_W'(i));
      hit_sel = acc_hit && (acc_vpn == VPN_W'(i));
      res_n   = res_vec[i];
      data_n  = data_q[i];
      use_n   = use_vec[i];
      mod_n   = mod_vec[i];
      if (clr_use) use_n = 1'b0;
      if (hit_sel) begin
        use_n = 1'b1;
        if (acc_wr) mod_n = 1'b1;
      end
      if (wr_sel) begin
        res_n  = tw_resident;
        data_n = tw_data;
        use_n  = 1'b0;
        mod_n  = 1'b0;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        res_vec[i] <= 1'b0;
        use_vec[i] <= 1'b0;
        mod_vec[i] <= 1'b0;
        data_q[i]  <= '0;
      end else begin
        res_vec[i] <= res_n;
        use_vec[i] <= use_n;
        mod_vec[i] <= mod_n;
        data_q[i]  <= data_n;
      end
    end
  end
endmodule

// File: rtl/vpx_victim.sv
module vpx_victim #(
  parameter int unsigned VPN_W = 6,
  localparam int unsigned N_ENT = 1 << VPN_W
) (
  input  logic [N_ENT-1:0] res_vec,
  input  logic [N_ENT-1:0] use_vec,
  input  logic [N_ENT-1:0] mod_vec,
  input  logic [VPN_W-1:0] start,
  output logic             found,
  output logic [VPN_W-1:0] vpn,
  output logic             dirty
);
  logic             cold_hit, any_hit;
  logic [VPN_W-1:0] cold_idx, any_idx, idx;

  always_comb begin
    cold_hit = 1'b0;
    any_hit  = 1'b0;
    cold_idx = '0;
    any_idx  = '0;
    idx      = '0;
    for (int i = 0; i < N_ENT; i++) begin
      idx = start + VPN_W'(i);
      if (res_vec[idx] && !use_vec[idx] && !cold_hit) begin
        cold_hit = 1'b1;
        cold_idx = idx;
      end
      if (res_vec[idx] && !any_hit) begin
        any_hit = 1'b1;
        any_idx = idx;
      end
    end
    found = any_hit;
    vpn   = cold_hit ? cold_idx : any_idx;
    dirty = any_hit && mod_vec[vpn];
  end
endmodule

// File: rtl/vpage_xlate.sv
module vpage_xlate
  import vpx_pkg::*;
#(
  parameter int unsigned VA_W      = VPX_VA_W,
  parameter int unsigned PAGE_BITS = VPX_PAGE_BITS,
  parameter int unsigned PPN_W     = VPX_PPN_W,
  parameter int unsigned SEC_W     = VPX_SEC_W,
  localparam int unsigned VPN_W    = VA_W - PAGE_BITS,
  localparam int unsigned PA_W     = PPN_W + PAGE_BITS,
  localparam int unsigned N_ENT    = 1 << VPN_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [VA_W-1:0]  req_va,
  input  logic             req_write,
  input  logic             clr_use,
  input  logic             tw_en,
  input  logic [VPN_W-1:0] tw_vpn,
  input  logic             tw_resident,
  input  logic [SEC_W-1:0] tw_data,
  output logic             rsp_valid,
  output logic [PA_W-1:0]  pa,
  output logic             fault,
  output logic [SEC_W-1:0] fault_sector,
  output logic             victim_found,
  output logic [VPN_W-1:0] victim_vpn,
  output logic             victim_dirty
);
  logic [VPN_W-1:0] req_vpn;
  logic             rd_resident;
  logic [SEC_W-1:0] rd_data;
  logic [N_ENT-1:0] res_vec, use_vec, mod_vec;
  logic [VPN_W-1:0] scan_start;
  logic             vic_found_n, vic_dirty_n;
  logic [VPN_W-1:0] vic_vpn_n;

  logic             rsp_valid_n, fault_n;
  logic [PA_W-1:0]  pa_n;
  logic [SEC_W-1:0] sector_n;

  assign req_vpn = req_va[VA_W-1:PAGE_BITS];

  vpx_table #(.VPN_W(VPN_W), .DATA_W(SEC_W)) table_i (
    .clk(clk), .rst_n(rst_n),
    .acc_en(req_valid), .acc_vpn(req_vpn), .acc_wr(req_write),
    .clr_use(clr_use),
    .tw_en(tw_en), .tw_vpn(tw_vpn), .tw_resident(tw_resident), .tw_data(tw_data),
    .rd_resident(rd_resident), .rd_data(rd_data),
    .res_vec(res_vec), .use_vec(use_vec), .mod_vec(mod_vec)
  );

  vpx_lfsr #(.W(VPN_W), .TAPS(VPN_W'(VPX_LFSR_TAPS))) lfsr_i (
    .clk(clk), .rst_n(rst_n), .q(scan_start)
  );

  vpx_victim #(.VPN_W(VPN_W)) victim_i (
    .res_vec(res_vec), .use_vec(use_vec), .mod_vec(mod_vec),
    .start(scan_start),
    .found(vic_found_n), .vpn(vic_vpn_n), .dirty(vic_dirty_n)
  );

  // next-state for the response registers
  always_comb begin
    rsp_valid_n = req_valid;
    fault_n     = fault;
    pa_n        = pa;
    sector_n    = fault_sector;
    if (req_valid) begin
      fault_n = !rd_resident;
      if (rd_resident) begin
        pa_n     = {rd_data[PPN_W-1:0], req_va[PAGE_BITS-1:0]};
        sector_n = '0;
      end else begin
        pa_n     = '0;
        sector_n = rd_data;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid    <= 1'b0;
      fault        <= 1'b0;
      pa           <= '0;
      fault_sector <= '0;
      victim_found <= 1'b0;
      victim_vpn   <= '0;
      victim_dirty <= 1'b0;
    end else begin
      rsp_valid    <= rsp_valid_n;
      fault        <= fault_n;
      pa           <= pa_n;
      fault_sector <= sector_n;
      victim_found <= vic_found_n;
      victim_vpn   <= vic_vpn_n;
      victim_dirty <= vic_dirty_n;
    end
  end
endmodule

// File: rtl/vpx_checker.sv
module vpx_checker #(
  parameter int unsigned VA_W      = 20,
  parameter int unsigned PAGE_BITS = 14,
  parameter int unsigned PA_W      = 18,
  parameter int unsigned SEC_W     = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic [VA_W-1:0]  req_va,
  input logic             rsp_valid,
  input logic [PA_W-1:0]  pa,
  input logic             fault,
  input logic             victim_found,
  input logic             victim_dirty
);
  // R10: a response follows every request, and only a request
  p_rsp_follows_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  p_no_spurious_rsp_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);
  // R1: the page offset passes through untouched on a hit
  p_offset_kept_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !$past(!rst_n)) ##1 (rsp_valid && !fault) |->
      pa[PAGE_BITS-1:0] == $past(req_va[PAGE_BITS-1:0]));
  // R2: a faulting response carries no physical address
  p_fault_no_pa_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && fault) |-> pa == '0);
  // R5/R6: no write-back flag without a proposed page
  p_empty_clean_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !victim_found |-> !victim_dirty);
endmodule

bind vpage_xlate vpx_checker #(
  .VA_W(VA_W), .PAGE_BITS(PAGE_BITS), .PA_W(PA_W), .SEC_W(SEC_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_va(req_va),
  .rsp_valid(rsp_valid), .pa(pa), .fault(fault),
  .victim_found(victim_found), .victim_dirty(victim_dirty)
);

// File: tb/vpage_xlate_tb_top.sv
`timescale 1ns/1ps
module vpage_xlate_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_write, clr_use, tw_en, tw_resident;
  logic [19:0] req_va;
  logic [5:0]  tw_vpn;
  logic [15:0] tw_data;
  logic        rsp_valid, fault, victim_found, victim_dirty;
  logic [17:0] pa;
  logic [15:0] fault_sector;
  logic [5:0]  victim_vpn;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  // reference model
  bit          m_res [64];
  bit          m_use [64];
  bit          m_mod [64];
  logic [15:0] m_data [64];

  always #2.5 clk = ~clk;

  vpage_xlate dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_va(req_va),
    .req_write(req_write), .clr_use(clr_use), .tw_en(tw_en), .tw_vpn(tw_vpn),
    .tw_resident(tw_resident), .tw_data(tw_data), .rsp_valid(rsp_valid),
    .pa(pa), .fault(fault), .fault_sector(fault_sector),
    .victim_found(victim_found), .victim_vpn(victim_vpn),
    .victim_dirty(victim_dirty)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [17:0] exp_pa(input logic [19:0] va);
    return m_res[va[19:14]] ? {m_data[va[19:14]][3:0], va[13:0]} : 18'h0;
  endfunction

  // one cycle with any mix of request, sweep and table write
  task automatic step(input bit acc, input logic [19:0] va, input bit wr,
                      input bit clr, input bit upd, input logic [5:0] uvpn,
                      input bit ures, input logic [15:0] udata);
    logic [5:0]  v;
    bit          hit;
    logic [17:0] epa;
    logic [15:0] esec;
    v = va[19:14];
    @(negedge clk);
    req_valid = acc; req_va = va; req_write = wr; clr_use = clr;
    tw_en = upd; tw_vpn = uvpn; tw_resident = ures; tw_data = udata;
    hit  = m_res[v];
    epa  = exp_pa(va);
    esec = m_data[v];
    @(posedge clk);
    #1;
    req_valid = 1'b0; clr_use = 1'b0; tw_en = 1'b0;
    if (acc) begin
      check(rsp_valid == 1'b1, "R10", "rsp_valid", 32'(rsp_valid), 1);
      check(fault == !hit, hit ? "R1" : "R2", "fault", 32'(fault), 32'(!hit));
      check(pa == epa, hit ? "R1" : "R2", "pa", 32'(pa), 32'(epa));
      if (!hit) check(fault_sector == esec, "R2", "fault_sector",
                      32'(fault_sector), 32'(esec));
    end else begin
      check(rsp_valid == 1'b0, "R10", "rsp_valid idle", 32'(rsp_valid), 0);
    end
    if (clr) for (int i = 0; i < 64; i++) m_use[i] = 1'b0;
    if (acc && hit) begin
      m_use[v] = 1'b1;
      if (wr) m_mod[v] = 1'b1;
    end
    if (upd) begin
      m_res[uvpn] = ures; m_data[uvpn] = udata;
      m_use[uvpn] = 1'b0; m_mod[uvpn] = 1'b0;
    end
  endtask

  task automatic acc_op(input logic [19:0] va, input bit wr);
    step(1'b1, va, wr, 1'b0, 1'b0, 6'd0, 1'b0, 16'd0);
  endtask
  task automatic upd_op(input logic [5:0] vpn, input bit res, input logic [15:0] d);
    step(1'b0, 20'd0, 1'b0, 1'b0, 1'b1, vpn, res, d);
  endtask
  task automatic clr_op();
    step(1'b0, 20'd0, 1'b0, 1'b1, 1'b0, 6'd0, 1'b0, 16'd0);
  endtask

  // idle cycle, then judge the eviction proposal against the model
  task automatic chk_victim(input string tag);
    bit any_res, any_cold;
    @(negedge clk);
    @(posedge clk);
    #1;
    any_res = 1'b0; any_cold = 1'b0;
    for (int i = 0; i < 64; i++) begin
      if (m_res[i]) any_res = 1'b1;
      if (m_res[i] && !m_use[i]) any_cold = 1'b1;
    end
    check(victim_found == any_res, "R5", "victim_found", 32'(victim_found), 32'(any_res));
    if (any_res) begin
      check(m_res[victim_vpn], "R5", "victim resident", 32'(victim_vpn), 32'(victim_vpn));
      if (any_cold)
        check(!m_use[victim_vpn], tag, "victim use bit clear", 32'(m_use[victim_vpn]), 0);
      check(victim_dirty == m_mod[victim_vpn], "R6", "victim_dirty",
            32'(victim_dirty), 32'(m_mod[victim_vpn]));
    end
  endtask

  task automatic expect_victim(input logic [5:0] vpn, input bit dirty, input string tag);
    chk_victim(tag);
    check(victim_vpn == vpn, tag, "victim_vpn", 32'(victim_vpn), 32'(vpn));
    check(victim_dirty == dirty, tag, "victim_dirty", 32'(victim_dirty), 32'(dirty));
  endtask

  initial begin
    #200000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < 64; i++) begin
      m_res[i] = 0; m_use[i] = 0; m_mod[i] = 0; m_data[i] = '0;
    end
    rst_n = 1'b0; req_valid = 0; req_va = '0; req_write = 0; clr_use = 0;
    tw_en = 0; tw_vpn = '0; tw_resident = 0; tw_data = '0;
    repeat (3) @(posedge clk);
    #1;
    // R8: reset state
    check(rsp_valid == 0 && fault == 0, "R8", "rsp/fault after reset", {30'd0, rsp_valid, fault}, 0);
    check(victim_found == 0, "R8", "victim_found after reset", 32'(victim_found), 0);
    @(negedge clk); rst_n = 1'b1;
    acc_op(20'h3C123, 1'b0); // R8: entry is non-resident, sector 0

    // R1, R2: worked mapping and fault cases
    upd_op(6'd2, 1'b1, 16'h0002);
    upd_op(6'd6, 1'b0, 16'd1239);
    acc_op(20'h08CAA, 1'b0);          // R1 expects pa 0x08CAA
    acc_op(20'h193C0, 1'b1);          // R2 expects sector 1239, R10 no marking
    step(0, 20'd0, 0, 0, 0, 6'd0, 0, 16'd0);
    expect_victim(6'd2, 1'b0, "R10");

    // R3, R4: use bits steer the proposal
    upd_op(6'd2, 1'b0, 16'd0);
    upd_op(6'd10, 1'b1, 16'h0005);
    upd_op(6'd20, 1'b1, 16'h0009);
    acc_op({6'd10, 14'h0011}, 1'b0);
    expect_victim(6'd20, 1'b0, "R3");
    acc_op({6'd20, 14'h3FFF}, 1'b0);
    chk_victim("R3");                  // all resident referenced: any resident
    clr_op();
    acc_op({6'd20, 14'h0000}, 1'b0);
    expect_victim(6'd10, 1'b0, "R4");

    // R6: write marks modified, read does not
    acc_op({6'd10, 14'h0123}, 1'b1);
    clr_op();
    acc_op({6'd20, 14'h0001}, 1'b0);
    expect_victim(6'd10, 1'b1, "R6");
    // R7: rewrite clears use and modified
    upd_op(6'd10, 1'b1, 16'h000C);
    expect_victim(6'd10, 1'b0, "R7");
    acc_op({6'd10, 14'h2AAA}, 1'b0);   // R7 new frame 0xC

    // R9: table write beats marking; hit beats sweep
    step(1, {6'd20, 14'h0042}, 1, 0, 1, 6'd20, 1, 16'h0003);
    expect_victim(6'd20, 1'b0, "R9");
    acc_op({6'd20, 14'h0042}, 1'b0);   // R9 new frame visible
    clr_op();
    step(1, {6'd10, 14'h0001}, 0, 1, 0, 6'd0, 0, 16'd0);
    expect_victim(6'd20, 1'b0, "R9");

    // constrained random mix
    for (int n = 0; n < 600; n++) begin
      int unsigned r;
      logic [5:0] vp;
      r  = $urandom_range(0, 99);
      vp = 6'($urandom_range(0, 15));
      if (r < 30)
        upd_op(vp, 1'($urandom_range(0, 3) != 0), 16'($urandom));
      else if (r < 36)
        clr_op();
      else if (r < 90)
        acc_op({vp, 14'($urandom)}, 1'($urandom_range(0, 1)));
      else
        step(1, {vp, 14'($urandom)}, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
             1'($urandom_range(0, 1)), 6'($urandom_range(0, 15)), 1'b1, 16'($urandom));
      if (n % 6 == 5) chk_victim("R5");
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule